// File: doc/BRIEF.md
# Converter Register Bank with Calibration and Result Latching

This block is the memory-mapped front end of an analog-to-digital converter. A host talks to it through a simple word-addressed port (valid, write, address, write data) and receives read data one cycle after the request. Writing a channel number to the channel-control register starts a conversion. The block passes the channel to a conversion sequencer through a start/result/done handshake. It then latches the sequencer's result, raises a completion flag and drives an interrupt line when the interrupt is enabled.

The bank also starts calibration when the host sets the calibration bit in the general-control register. That bit reads back as one while calibration runs and clears itself when the analog side reports completion. The pass/fail outcome is recorded in a separate general-status register. A configuration bit decides what happens when a new result arrives before the previous one has been read: the new value replaces the old one, or the old value is kept.

Top module: `adc_ctl_regs`

## Requirements
- R1: After reset, the channel-control register (offset 0x00) reads 0x1F. Status (0x08), result (0x0C), configuration (0x14), general control (0x18) and general status (0x1C) all read zero. irq, seq_start and cal_start are low.
- R2: A write to offset 0x00 stores the channel from bits 4:0 and the interrupt enable from bit 7. If the channel is not 0x1F, seq_start is high for exactly the cycle after the write and seq_chan carries the channel. Writing channel 0x1F starts nothing.
- R3: When seq_done is high, seq_result is latched into the result register, as far as R6 permits, and status bit 0 (the completion flag) becomes one.
- R4: irq is high exactly when the completion flag is one and channel-control bit 7 is one.
- R5: A read of offset 0x0C returns the latched result, zero-extended, and clears the completion flag. A read of offset 0x08 returns the flag without clearing it. Read data appears on bus_rdata in the cycle after the request.
- R6: Configuration bit 16 governs overwrite. When it is one, a new result replaces an unread one. When it is zero and the flag is already set, the earlier result is kept.
- R7: Writing one to general-control bit 7 while calibration is idle gives a one-cycle cal_start pulse. The bit then reads one until cal_done arrives, and reads zero afterwards.
- R8: When calibration finishes, general-status bit 1 takes the value of cal_fail, and the completion flag is set.
- R9: General-control bit 6 drives seq_continuous and bit 5 drives seq_average. Both bits read back from offset 0x18.
- R10: A read of an offset that is misaligned, above 0x30, or unimplemented (0x04, 0x10, 0x20 to 0x30) returns zero. A write to such an offset changes no register and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after a read request |
| seq_start | output | 1 | One-cycle conversion request |
| seq_chan | output | 5 | Channel to convert |
| seq_continuous | output | 1 | Continuous conversion enable |
| seq_average | output | 1 | Averaging enable |
| seq_done | input | 1 | Result valid strobe from the sequencer |
| seq_result | input | RES_W (12) | Conversion result |
| cal_start | output | 1 | One-cycle calibration request |
| cal_done | input | 1 | Calibration finished |
| cal_fail | input | 1 | Calibration outcome, sampled with cal_done |
| irq | output | 1 | Completion interrupt |

## Verification
The bench delivers two results back to back with overwrite disabled and then enabled. A bank that ignored the policy would return the second value in the first case, or the first value in the second. It confirms that reading status leaves the flag set while reading the result clears it, and that irq follows the enable bit. A design that coupled irq to the flag alone would raise the line with the enable off. Calibration is run once failing and once passing, which catches a self-clearing bit that sticks or a failure flag that never updates. Misaligned and out-of-range addresses that alias the channel register under a naive word decode are written and read, exposing any partial decode that would start a conversion or return register contents.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;

  localparam logic [7:0] OFF_CHAN  = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h08;
  localparam logic [7:0] OFF_RES   = 8'h0C;
  localparam logic [7:0] OFF_CFG   = 8'h14;
  localparam logic [7:0] OFF_GCTL  = 8'h18;
  localparam logic [7:0] OFF_GSTAT = 8'h1C;
  localparam logic [7:0] OFF_LIMIT = 8'h30;

  localparam int CHAN_W   = 5;
  localparam logic [CHAN_W-1:0] CHAN_IDLE = 5'h1F;
  localparam int BIT_IE   = 7;
  localparam int BIT_CAL  = 7;
  localparam int BIT_CONT = 6;
  localparam int BIT_AVG  = 5;
  localparam int BIT_CALF = 1;
  localparam int BIT_OVW  = 16;
  localparam int CFG_W    = BIT_OVW + 1;
  localparam int GCTL_W   = BIT_CAL;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CHAN, SEL_STAT, SEL_RES, SEL_CFG, SEL_GCTL, SEL_GSTAT
  } reg_sel_e;

  function automatic reg_sel_e offset_to_sel(input logic [7:0] off);
    case (off)
      OFF_CHAN:  return SEL_CHAN;
      OFF_STAT:  return SEL_STAT;
      OFF_RES:   return SEL_RES;
      OFF_CFG:   return SEL_CFG;
      OFF_GCTL:  return SEL_GCTL;
      OFF_GSTAT: return SEL_GSTAT;
      default:   return SEL_NONE;
    endcase
  endfunction

  function automatic logic chan_starts(input logic [CHAN_W-1:0] chan);
    return chan != CHAN_IDLE;
  endfunction

  function automatic logic may_replace(input logic flag_set, input logic ovw_en);
    return !flag_set || ovw_en;
  endfunction

endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
  import adc_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              addr_ok,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(OFF_LIMIT);

  always_comb begin
    addr_ok = (bus_addr[1:0] == 2'b00) && (bus_addr <= LIMIT);
    sel     = addr_ok ? offset_to_sel(bus_addr[7:0]) : SEL_NONE;
  end
endmodule

// File: rtl/adc_conv_ctl.sv
module adc_conv_ctl
  import adc_regs_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_chan,
  input  logic [7:0]        wdata_lo,
  input  logic              rd_result,
  input  logic              seq_done,
  input  logic [RES_W-1:0]  seq_result,
  input  logic              cal_finish,
  input  logic              ovw_en,
  output logic [CHAN_W-1:0] chan_q,
  output logic              ie_q,
  output logic              coco_q,
  output logic [RES_W-1:0]  result_q,
  output logic              seq_start,
  output logic              result_accept
);
  assign result_accept = seq_done && may_replace(coco_q, ovw_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q    <= CHAN_IDLE;
      ie_q      <= 1'b0;
      seq_start <= 1'b0;
    end else begin
      seq_start <= 1'b0;
      if (wr_chan) begin
        chan_q    <= wdata_lo[CHAN_W-1:0];
        ie_q      <= wdata_lo[BIT_IE];
        seq_start <= chan_starts(wdata_lo[CHAN_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      coco_q   <= 1'b0;
    end else begin
      if (result_accept) result_q <= seq_result;
      if (result_accept || cal_finish) coco_q <= 1'b1;
      else if (rd_result)              coco_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_cal_ctl.sv
module adc_cal_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_req,
  input  logic cal_done,
  input  logic cal_fail,
  output logic cal_busy,
  output logic calf_q,
  output logic cal_start,
  output logic cal_finish
);
  assign cal_finish = cal_busy && cal_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_busy  <= 1'b0;
      calf_q    <= 1'b0;
      cal_start <= 1'b0;
    end else begin
      cal_start <= 1'b0;
      if (cal_finish) begin
        cal_busy <= 1'b0;
        calf_q   <= cal_fail;
      end else if (cal_req && !cal_busy) begin
        cal_busy  <= 1'b1;
        cal_start <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
  import adc_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              seq_start,
  output logic [CHAN_W-1:0] seq_chan,
  output logic              seq_continuous,
  output logic              seq_average,
  input  logic              seq_done,
  input  logic [RES_W-1:0]  seq_result,
  output logic              cal_start,
  input  logic              cal_done,
  input  logic              cal_fail,
  output logic              irq
);
  logic              addr_ok;
  reg_sel_e          sel;
  logic              wr_hit, rd_hit;
  logic              wr_chan, wr_cfg, wr_gctl, rd_result;
  logic [CHAN_W-1:0] chan_q;
  logic              ie_q, coco_q, result_accept;
  logic [RES_W-1:0]  result_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [GCTL_W-1:0] gctl_q;
  logic              cal_busy, calf_q, cal_finish, ovw_en;
  logic [DATA_W-1:0] rdata_d;

  adc_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
    .bus_addr (bus_addr),
    .addr_ok  (addr_ok),
    .sel      (sel)
  );

  assign wr_hit    = bus_valid && bus_write;
  assign rd_hit    = bus_valid && !bus_write;
  assign wr_chan   = wr_hit && (sel == SEL_CHAN);
  assign wr_cfg    = wr_hit && (sel == SEL_CFG);
  assign wr_gctl   = wr_hit && (sel == SEL_GCTL);
  assign rd_result = rd_hit && (sel == SEL_RES);
  assign ovw_en    = cfg_q[BIT_OVW];

  adc_conv_ctl #(.RES_W(RES_W)) conv_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_chan       (wr_chan),
    .wdata_lo      (bus_wdata[7:0]),
    .rd_result     (rd_result),
    .seq_done      (seq_done),
    .seq_result    (seq_result),
    .cal_finish    (cal_finish),
    .ovw_en        (ovw_en),
    .chan_q        (chan_q),
    .ie_q          (ie_q),
    .coco_q        (coco_q),
    .result_q      (result_q),
    .seq_start     (seq_start),
    .result_accept (result_accept)
  );

  adc_cal_ctl cal_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_req    (wr_gctl && bus_wdata[BIT_CAL]),
    .cal_done   (cal_done),
    .cal_fail   (cal_fail),
    .cal_busy   (cal_busy),
    .calf_q     (calf_q),
    .cal_start  (cal_start),
    .cal_finish (cal_finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      gctl_q <= '0;
    end else begin
      if (wr_cfg)  cfg_q  <= bus_wdata[CFG_W-1:0];
      if (wr_gctl) gctl_q <= bus_wdata[GCTL_W-1:0];
    end
  end

  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_CHAN: begin
        rdata_d[CHAN_W-1:0] = chan_q;
        rdata_d[BIT_IE]     = ie_q;
      end
      SEL_STAT:  rdata_d[0] = coco_q;
      SEL_RES:   rdata_d[RES_W-1:0] = result_q;
      SEL_CFG:   rdata_d[CFG_W-1:0] = cfg_q;
      SEL_GCTL: begin
        rdata_d[GCTL_W-1:0] = gctl_q;
        rdata_d[BIT_CAL]    = cal_busy;
      end
      SEL_GSTAT: rdata_d[BIT_CALF] = calf_q;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= rdata_d;
    else             bus_rdata <= '0;
  end

  assign seq_chan       = chan_q;
  assign seq_continuous = gctl_q[BIT_CONT];
  assign seq_average    = gctl_q[BIT_AVG];
  assign irq            = coco_q && ie_q;
endmodule

// File: rtl/adc_ctl_regs_chk.sv
module adc_ctl_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RES_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              seq_start,
  input logic              seq_done,
  input logic              irq,
  input logic              coco_q,
  input logic [RES_W-1:0]  result_q,
  input logic              ovw_en,
  input logic              rd_result,
  input logic              addr_ok,
  input logic              cal_start,
  input logic              cal_busy,
  input logic              cal_done
);
  p_start_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && addr_ok && (bus_addr == '0) && (bus_wdata[4:0] != 5'h1F)
    |=> seq_start);

  p_done_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && !rd_result |=> coco_q);

  p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> coco_q);

  p_keep_unread_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && coco_q && !ovw_en |=> $stable(result_q));

  p_cal_busy_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> cal_busy);

  p_cal_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy && cal_done |=> !cal_busy);

  p_bad_addr_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && !addr_ok |=> (bus_rdata == '0));
endmodule

bind adc_ctl_regs adc_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .seq_start (seq_start),
  .seq_done  (seq_done),
  .irq       (irq),
  .coco_q    (coco_q),
  .result_q  (result_q),
  .ovw_en    (ovw_en),
  .rd_result (rd_result),
  .addr_ok   (addr_ok),
  .cal_start (cal_start),
  .cal_busy  (cal_busy),
  .cal_done  (cal_done)
);

// File: tb/adc_ctl_regs_tb_top.sv
module adc_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        seq_start, seq_continuous, seq_average, cal_start, irq;
  logic [4:0]  seq_chan;
  logic        seq_done = 1'b0, cal_done = 1'b0, cal_fail = 1'b0;
  logic [11:0] seq_result = '0;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        mon_arm = 1'b0;
  logic        done_flag = 1'b0;

  always #10 clk = ~clk;

  adc_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seq_start(seq_start), .seq_chan(seq_chan), .seq_continuous(seq_continuous),
    .seq_average(seq_average), .seq_done(seq_done), .seq_result(seq_result),
    .cal_start(cal_start), .cal_done(cal_done), .cal_fail(cal_fail), .irq(irq)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) mon_arm <= bus_valid && !bus_write;

  // monitor: pops expected read data, compares in the cycle after the request
  always @(negedge clk) begin
    if (mon_arm) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard-empty", bus_rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk); bus_valid = 1'b0;
  endtask

  task automatic seq_pulse(input logic [11:0] v);
    @(negedge clk); seq_done = 1'b1; seq_result = v;
    @(negedge clk); seq_done = 1'b0;
  endtask

  task automatic cal_pulse(input logic f);
    @(negedge clk); cal_done = 1'b1; cal_fail = f;
    @(negedge clk); cal_done = 1'b0; cal_fail = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(irq == 1'b0 && seq_start == 1'b0 && cal_start == 1'b0, "R1 outputs idle",
          {29'b0, irq, seq_start, cal_start}, 32'h0);
    bus_rd(8'h00, 32'h1F, "R1 chan reset");
    bus_rd(8'h08, 32'h0, "R1 status reset");
    bus_rd(8'h0C, 32'h0, "R1 result reset");
    bus_rd(8'h14, 32'h0, "R1 cfg reset");
    bus_rd(8'h18, 32'h0, "R1 gctl reset");
    bus_rd(8'h1C, 32'h0, "R1 gstat reset");

    // R2 start on channel write
    bus_wr(8'h00, 32'h83);
    check(seq_start === 1'b1, "R2 start pulse", {31'b0, seq_start}, 32'h1);
    check(seq_chan === 5'd3, "R2 channel", {27'b0, seq_chan}, 32'h3);
    @(negedge clk);
    check(seq_start === 1'b0, "R2 single cycle", {31'b0, seq_start}, 32'h0);
    bus_rd(8'h00, 32'h83, "R2 chan readback");
    bus_wr(8'h00, 32'h9F);
    check(seq_start === 1'b0, "R2 idle channel no start", {31'b0, seq_start}, 32'h0);

    // R3/R4/R5 latch, irq, read clear
    seq_pulse(12'hABC);
    check(irq === 1'b1, "R4 irq with enable", {31'b0, irq}, 32'h1);
    bus_rd(8'h08, 32'h1, "R3 flag set");
    bus_rd(8'h08, 32'h1, "R5 status read keeps flag");
    bus_rd(8'h0C, 32'hABC, "R5 result value");
    bus_rd(8'h08, 32'h0, "R5 flag cleared by result read");
    check(irq === 1'b0, "R4 irq drops with flag", {31'b0, irq}, 32'h0);

    // R6 overwrite disabled then enabled
    seq_pulse(12'h111);
    seq_pulse(12'h222);
    bus_rd(8'h0C, 32'h111, "R6 old result kept");
    bus_wr(8'h14, 32'h1_0000);
    bus_rd(8'h14, 32'h1_0000, "R6 cfg readback");
    seq_pulse(12'h333);
    seq_pulse(12'h444);
    bus_rd(8'h0C, 32'h444, "R6 new result replaces");

    // R4 enable off
    bus_wr(8'h00, 32'h1F);
    seq_pulse(12'h555);
    check(irq === 1'b0, "R4 no irq when disabled", {31'b0, irq}, 32'h0);
    bus_rd(8'h08, 32'h1, "R3 flag set without enable");
    bus_rd(8'h0C, 32'h555, "R3 result latched");

    // R9 continuous / average
    bus_wr(8'h18, 32'h60);
    check(seq_continuous === 1'b1 && seq_average === 1'b1, "R9 mode outputs",
          {30'b0, seq_continuous, seq_average}, 32'h3);
    bus_rd(8'h18, 32'h60, "R9 gctl readback");

    // R7/R8 calibration, failing then passing
    bus_wr(8'h18, 32'hE0);
    check(cal_start === 1'b1, "R7 cal start pulse", {31'b0, cal_start}, 32'h1);
    bus_rd(8'h18, 32'hE0, "R7 cal bit busy");
    check(cal_start === 1'b0, "R7 cal start single", {31'b0, cal_start}, 32'h0);
    cal_pulse(1'b1);
    bus_rd(8'h18, 32'h60, "R7 cal bit self-clears");
    bus_rd(8'h1C, 32'h2, "R8 failure flag");
    bus_rd(8'h08, 32'h1, "R8 completion flag on cal");
    bus_rd(8'h0C, 32'h555, "R8 result unchanged by cal");
    bus_wr(8'h18, 32'h80);
    cal_pulse(1'b0);
    bus_rd(8'h1C, 32'h0, "R8 pass clears failure");
    bus_rd(8'h18, 32'h0, "R7 idle after second cal");

    // R10 invalid offsets
    bus_wr(8'h24, 32'hFFFF_FFFF);
    bus_rd(8'h24, 32'h0, "R10 unimplemented read");
    bus_wr(8'h01, 32'h85);
    check(seq_start === 1'b0, "R10 misaligned write no start", {31'b0, seq_start}, 32'h0);
    bus_wr(8'h40, 32'h86);
    check(seq_start === 1'b0, "R10 out-of-range write no start", {31'b0, seq_start}, 32'h0);
    bus_wr(8'h16, 32'h0);
    bus_rd(8'h00, 32'h1F, "R10 chan untouched");
    bus_rd(8'h14, 32'h1_0000, "R10 cfg untouched");
    bus_rd(8'h02, 32'h0, "R10 misaligned read");
    bus_rd(8'h40, 32'h0, "R10 out-of-range read");
    bus_rd(8'h04, 32'h0, "R10 hole read");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule